// File: doc/BRIEF.md
# Interlocked Flash Control Register Bank

This block holds the byte-wide registers that steer an on-chip flash array. Software selects program, erase or verify operation by writing a control byte. A write only counts when a chain of hardware conditions holds. A gate bit in a separate register must be set, and the chip must be running in a mode with flash enabled. The external write-enable pin must be high, and software must have set its own enable bit first. A setup bit must come before its matching operation bit.

Whenever the pin or the software enable is missing, the block forces the dependent state back to zero. The flash array therefore never sees a stray program or erase request. The decoded operating mode and the erase block select lines are brought out for the array sequencer.

Top module: `flash_ctl_bank`

## Requirements
- R1: The gate register at 0xFDB4 is always readable and writable. Only its bit 3 is stored, and its other bits read as 0. While bit 3 is 0, reads of the registers at 0xFFA8 to 0xFFAC return 0x00 and writes to them are discarded.
- R2: While `flash_mode_on` is 0, reads of 0xFFA8 to 0xFFAC return 0x00 and writes to them are discarded, even with the gate bit set.
- R3: Bit 7 of control register 1 (0xFFA8) reads the level of `prog_pin`. After reset it reads 0x80 with the pin high and 0x00 with the pin low. Writes to 0xFFA8 to 0xFFAC are discarded while the pin is low.
- R4: Control register 1 bit layout: 6 software enable, 5 erase setup, 4 program setup, 3 erase verify, 2 program verify, 1 erase, 0 program.
- R5: Bits 5 to 2 of control register 1 take the written value only if software enable was already 1 before the write. A write with bit 6 equal to 0 clears bits 6 to 0.
- R6: A write setting the program bit leaves it 0 unless program setup was already 1. A write setting the erase bit leaves it 0 unless erase setup was already 1.
- R7: While `prog_pin` is low, bits 6 to 0 of control register 1 read 0 with no clock delay. They stay cleared after the pin returns high.
- R8: Control register 2 (0xFFA9), erase block 1 (0xFFAA), erase block 2 (0xFFAB) and power control (0xFFAC) are plain read/write bytes. They read 0x00 and are cleared whenever the pin is low or software enable is 0.
- R9: `erase_blk` equals erase block 2 in bits 15 to 8 and erase block 1 in bits 7 to 0.
- R10: `op_mode` encoding: 0 idle, 1 program setup, 2 program, 3 erase setup, 4 erase, 5 program verify, 6 erase verify. The priority is program, erase, program verify, erase verify, program setup, erase setup, then idle.
- R11: Reset clears the gate bit and all stored control bits. `op_mode` is then 0 and `erase_blk` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 16 | Byte address |
| wr_en | input | 1 | Write strobe, one byte per cycle |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr`, combinational |
| prog_pin | input | 1 | Level of the external write-enable pin |
| flash_mode_on | input | 1 | Operating mode has on-chip flash enabled |
| op_mode | output | 3 | Decoded flash operating mode |
| erase_blk | output | 16 | Erase block select bits |

## Verification
The checker assumes that `prog_pin` and `flash_mode_on` are quasi-static levels that stay steady between clock edges. It also assumes that the bus presents at most one write per cycle, with the address held steady for the whole cycle. The ordering properties rely on program and erase being reachable only through a write, so they presume no hidden path sets those bits. The stimulus changes every input only at the falling clock edge. It holds the pin low for at least one full rising edge whenever it drops the pin, and it reads back state only on cycles with no write.

// File: rtl/flctl_pkg.sv
package flctl_pkg;
   typedef enum logic [2:0] {
      FM_IDLE   = 3'd0,
      FM_PSETUP = 3'd1,
      FM_PROG   = 3'd2,
      FM_ESETUP = 3'd3,
      FM_ERASE  = 3'd4,
      FM_PVER   = 3'd5,
      FM_EVER   = 3'd6
   } flmode_e;

   localparam int C1_SWE = 6;
   localparam int C1_ESU = 5;
   localparam int C1_PSU = 4;
   localparam int C1_EV  = 3;
   localparam int C1_PV  = 2;
   localparam int C1_E   = 1;
   localparam int C1_P   = 0;
endpackage

// File: rtl/flctl_gate.sv
module flctl_gate #(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int GATE_BIT = 3,
   parameter logic [ADDR_W-1:0] GATE_ADDR = 16'hFDB4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic              wr_bit,
   output logic              hit,
   output logic              gate_on,
   output logic [DATA_W-1:0] rd_val
);
   logic gate_r;

   assign hit = (addr == GATE_ADDR);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gate_r <= 1'b0;
      end else if (wr_en && hit) begin
         gate_r <= wr_bit;
      end
   end

   assign gate_on = gate_r;

   always_comb begin
      rd_val = '0;
      rd_val[GATE_BIT] = gate_r;
   end
endmodule

// File: rtl/flctl_ctrl1.sv
module flctl_ctrl1
   import flctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       pin,
   input  logic       wr_acc,
   input  logic [6:0] wd,
   output logic [6:0] bits
);
   logic [6:0] st_r;
   logic [6:0] st_n;

   always_comb begin
      st_n = st_r;
      if (wr_acc) begin
         st_n = '0;
         if (wd[C1_SWE]) begin
            st_n[C1_SWE] = 1'b1;
            if (st_r[C1_SWE]) begin
               st_n[C1_ESU:C1_PV] = wd[C1_ESU:C1_PV];
               st_n[C1_P] = wd[C1_P] & st_r[C1_PSU];
               st_n[C1_E] = wd[C1_E] & st_r[C1_ESU];
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_r <= '0;
      end else if (!pin) begin
         st_r <= '0;
      end else begin
         st_r <= st_n;
      end
   end

   assign bits = pin ? st_r : '0;
endmodule

// File: rtl/flctl_byte_reg.sv
module flctl_byte_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en,
   input  logic              wr_acc,
   input  logic [DATA_W-1:0] wd,
   output logic [DATA_W-1:0] q
);
   logic [DATA_W-1:0] q_r;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q_r <= '0;
      end else if (!en) begin
         q_r <= '0;
      end else if (wr_acc) begin
         q_r <= wd;
      end
   end

   assign q = en ? q_r : '0;
endmodule

// File: rtl/flctl_mode_dec.sv
module flctl_mode_dec
   import flctl_pkg::*;
(
   input  logic [6:0] bits,
   output logic [2:0] mode
);
   flmode_e m;

   always_comb begin
      if (bits[C1_P])        m = FM_PROG;
      else if (bits[C1_E])   m = FM_ERASE;
      else if (bits[C1_PV])  m = FM_PVER;
      else if (bits[C1_EV])  m = FM_EVER;
      else if (bits[C1_PSU]) m = FM_PSETUP;
      else if (bits[C1_ESU]) m = FM_ESETUP;
      else                   m = FM_IDLE;
   end

   assign mode = m;
endmodule

// File: rtl/flash_ctl_bank.sv
module flash_ctl_bank
   import flctl_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 8,
   parameter int GATE_BIT = 3,
   parameter logic [ADDR_W-1:0] GATE_ADDR = 16'hFDB4,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFFA8,
   parameter bit SYNC_PIN = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic              wr_en,
   input  logic [DATA_W-1:0] wr_data,
   output logic [DATA_W-1:0] rd_data,
   input  logic              prog_pin,
   input  logic              flash_mode_on,
   output logic [2:0]        op_mode,
   output logic [2*DATA_W-1:0] erase_blk
);
   localparam int NAUX   = 4;
   localparam int AUX_EB1 = 1;
   localparam int AUX_EB2 = 2;

   if (DATA_W != 8) begin : g_bad_width
      $error("flash_ctl_bank: DATA_W must be 8");
   end
   if (GATE_BIT >= DATA_W) begin : g_bad_gate
      $error("flash_ctl_bank: GATE_BIT out of range");
   end

   logic pin_s;
   if (SYNC_PIN) begin : g_pin_sync
      logic [1:0] sync_r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sync_r <= '0;
         else        sync_r <= {sync_r[0], prog_pin};
      end
      assign pin_s = sync_r[1];
   end else begin : g_pin_direct
      assign pin_s = prog_pin;
   end

   logic              gate_hit;
   logic              gate_on;
   logic [DATA_W-1:0] gate_rd;

   flctl_gate #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .GATE_BIT(GATE_BIT), .GATE_ADDR(GATE_ADDR)
   ) u_gate (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_bit(wr_data[GATE_BIT]), .hit(gate_hit),
      .gate_on(gate_on), .rd_val(gate_rd)
   );

   logic acc_ok;
   logic wr_ok;
   assign acc_ok = gate_on & flash_mode_on;
   assign wr_ok  = acc_ok & wr_en & pin_s;

   logic       c1_hit;
   logic [6:0] c1_bits;
   assign c1_hit = (addr == BASE_ADDR);

   flctl_ctrl1 u_c1 (
      .clk(clk), .rst_n(rst_n), .pin(pin_s),
      .wr_acc(wr_ok & c1_hit), .wd(wr_data[6:0]), .bits(c1_bits)
   );

   logic aux_en;
   assign aux_en = pin_s & c1_bits[C1_SWE];

   logic [DATA_W-1:0] aux_q [NAUX];
   logic [NAUX-1:0]   aux_hit;

   for (genvar i = 0; i < NAUX; i++) begin : g_aux
      localparam logic [ADDR_W-1:0] A_ADDR = BASE_ADDR + ADDR_W'(i + 1);
      assign aux_hit[i] = (addr == A_ADDR);
      flctl_byte_reg #(.DATA_W(DATA_W)) u_reg (
         .clk(clk), .rst_n(rst_n), .en(aux_en),
         .wr_acc(wr_ok & aux_hit[i]), .wd(wr_data), .q(aux_q[i])
      );
   end

   always_comb begin
      rd_data = '0;
      if (gate_hit) begin
         rd_data = gate_rd;
      end else if (acc_ok) begin
         if (c1_hit) rd_data = {pin_s, c1_bits};
         for (int k = 0; k < NAUX; k++) begin
            if (aux_hit[k]) rd_data = aux_q[k];
         end
      end
   end

   flctl_mode_dec u_dec (.bits(c1_bits), .mode(op_mode));

   assign erase_blk = {aux_q[AUX_EB2], aux_q[AUX_EB1]};
endmodule

// File: rtl/flctl_chk.sv
module flctl_chk #(
   parameter int ADDR_W = 16,
   parameter logic [ADDR_W-1:0] GATE_ADDR = 16'hFDB4,
   parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFFA8
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] addr,
   input logic              wr_en,
   input logic              flash_mode_on,
   input logic [7:0]        rd_data,
   input logic [2:0]        op_mode,
   input logic [15:0]       erase_blk,
   input logic              pin_s,
   input logic              gate_on,
   input logic [6:0]        c1_bits
);
   // R1
   gate_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == BASE_ADDR && !gate_on && pin_s)
      |=> ($stable(c1_bits) || !pin_s));

   // R2
   fm_off_rd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!flash_mode_on && addr != GATE_ADDR) |-> (rd_data == 8'h00));

   // R7
   pin_low_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pin_s |-> (op_mode == 3'd0));

   // R6
   prog_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(op_mode == 3'd2) |-> $past(c1_bits[4]));

   // R6
   erase_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(op_mode == 3'd4) |-> $past(c1_bits[5]));

   // R8
   eblk_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (erase_blk != 16'h0) |-> (pin_s && c1_bits[6]));

   // R10
   mode_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
      op_mode != 3'd7);
endmodule

bind flash_ctl_bank flctl_chk #(
   .ADDR_W(ADDR_W), .GATE_ADDR(GATE_ADDR), .BASE_ADDR(BASE_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
   .flash_mode_on(flash_mode_on), .rd_data(rd_data), .op_mode(op_mode),
   .erase_blk(erase_blk), .pin_s(pin_s), .gate_on(gate_on), .c1_bits(c1_bits)
);

// File: tb/sim_flash_ctl_bank.sv
module sim_flash_ctl_bank;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 19;

   // fields: write addr, write data, read addr, expected read, expected mode
   localparam logic [50:0] VEC [NV] = '{
      {16'hFFA8, 8'h40, 16'hFFA8, 8'h00, 3'd0},
      {16'hFDB4, 8'hFF, 16'hFDB4, 8'h08, 3'd0},
      {16'h0000, 8'h00, 16'hFFA8, 8'h80, 3'd0},
      {16'hFFA8, 8'h50, 16'hFFA8, 8'hC0, 3'd0},
      {16'hFFA8, 8'h41, 16'hFFA8, 8'hC0, 3'd0},
      {16'hFFA8, 8'h50, 16'hFFA8, 8'hD0, 3'd1},
      {16'hFFA8, 8'h51, 16'hFFA8, 8'hD1, 3'd2},
      {16'hFFA8, 8'h55, 16'hFFA8, 8'hD5, 3'd2},
      {16'hFFA8, 8'h44, 16'hFFA8, 8'hC4, 3'd5},
      {16'hFFA8, 8'h60, 16'hFFA8, 8'hE0, 3'd3},
      {16'hFFA8, 8'h62, 16'hFFA8, 8'hE2, 3'd4},
      {16'hFFA8, 8'h48, 16'hFFA8, 8'hC8, 3'd6},
      {16'hFFAA, 8'h5A, 16'hFFAA, 8'h5A, 3'd6},
      {16'hFFAB, 8'hA5, 16'hFFAB, 8'hA5, 3'd6},
      {16'hFFA9, 8'h33, 16'hFFA9, 8'h33, 3'd6},
      {16'hFFAC, 8'h11, 16'hFFAC, 8'h11, 3'd6},
      {16'hFFA8, 8'h00, 16'hFFA8, 8'h80, 3'd0},
      {16'hFDB4, 8'h00, 16'hFDB4, 8'h00, 3'd0},
      {16'hFDB4, 8'h08, 16'hFFAA, 8'h00, 3'd0}
   };

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] addr = '0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_data = '0;
   logic [7:0]  rd_data;
   logic        prog_pin = 1'b1;
   logic        flash_mode_on = 1'b1;
   logic [2:0]  op_mode;
   logic [15:0] erase_blk;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   flash_ctl_bank u0 (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en),
      .wr_data(wr_data), .rd_data(rd_data), .prog_pin(prog_pin),
      .flash_mode_on(flash_mode_on), .op_mode(op_mode), .erase_blk(erase_blk)
   );

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [15:0] a, input logic [7:0] d);
      @(negedge clk);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd_chk(input string req, input logic [15:0] a, input logic [7:0] exp);
      addr = a;
      #1;
      check(req, {8'h00, rd_data}, {8'h00, exp});
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   initial begin
      // R11 reset state
      addr = 16'hFDB4;
      #1;
      check("R11 gate after reset", {8'h00, rd_data}, 16'h0000);
      check("R11 mode after reset", {13'h0, op_mode}, 16'h0000);
      check("R11 erase_blk after reset", erase_blk, 16'h0000);
      @(negedge clk);
      rst_n = 1'b1;

      // table: R1 R3 R4 R5 R6 R8 R10
      for (int i = 0; i < NV; i++) begin
         wr(VEC[i][50:35], VEC[i][34:27]);
         rd_chk($sformatf("R1/R4/R5/R6/R8/R10 vector %0d read", i), VEC[i][26:11], VEC[i][10:3]);
         check($sformatf("R10 vector %0d mode", i), {13'h0, op_mode}, {13'h0, VEC[i][2:0]});
      end

      // R9 erase block output
      wr(16'hFFA8, 8'h40);
      wr(16'hFFAA, 8'h5A);
      wr(16'hFFAB, 8'hA5);
      #1;
      check("R9 erase_blk", erase_blk, 16'hA55A);

      // R2 flash mode off
      flash_mode_on = 1'b0;
      rd_chk("R2 read with flash off", 16'hFFAA, 8'h00);
      wr(16'hFFAA, 8'h77);
      flash_mode_on = 1'b1;
      rd_chk("R2 write with flash off ignored", 16'hFFAA, 8'h5A);

      // R7 / R8 pin low
      @(negedge clk);
      wr(16'hFFA8, 8'h50);
      #1;
      check("R10 setup before pin drop", {13'h0, op_mode}, 16'h0001);
      @(negedge clk);
      prog_pin = 1'b0;
      #1;
      check("R7 mode idle at pin low", {13'h0, op_mode}, 16'h0000);
      check("R8 erase_blk zero at pin low", erase_blk, 16'h0000);
      rd_chk("R3 ctrl1 with pin low", 16'hFFA8, 8'h00);
      wr(16'hFFA8, 8'h40);
      @(negedge clk);
      prog_pin = 1'b1;
      rd_chk("R7 bits stay cleared", 16'hFFA8, 8'h80);
      check("R8 erase_blk cleared", erase_blk, 16'h0000);

      // R1 gate off blocks aux write
      wr(16'hFFA8, 8'h40);
      wr(16'hFDB4, 8'h00);
      wr(16'hFFAA, 8'h12);
      wr(16'hFDB4, 8'h08);
      rd_chk("R1 aux write with gate off ignored", 16'hFFAA, 8'h00);

      // R11 reset mid-operation
      wr(16'hFFA8, 8'h50);
      do_reset();
      #1;
      check("R11 mode after mid reset", {13'h0, op_mode}, 16'h0000);
      rd_chk("R11 gate cleared by reset", 16'hFDB4, 8'h00);

      // R3 reset with pin low
      @(negedge clk);
      prog_pin = 1'b0;
      do_reset();
      wr(16'hFDB4, 8'h08);
      rd_chk("R3 ctrl1 after reset pin low", 16'hFFA8, 8'h00);
      @(negedge clk);
      prog_pin = 1'b1;
      rd_chk("R3 ctrl1 pin high", 16'hFFA8, 8'h80);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 20000);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog all requirements actual=running expected=done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end
endmodule